// File: doc/BRIEF.md
# Single-Accumulator Multicycle Processor

This block is a small processor built around one accumulator. It runs a program held in a memory that stores both instructions and data. The block keeps repeating the same sequence: it reads the word the program counter points at, decodes its opcode, and then carries out the operation. It does not start the next instruction until the current one is finished. Every transfer to or from memory passes through a memory-address register and a memory-data register. A small transfer controller owns those two registers and the direction of each transfer.

The memory is external and synchronous. The processor drives an address, write data and a one-cycle write strobe. Read data comes back one cycle after the address is presented. Three condition flags (greater, equal, less) control the conditional jumps, and only the compare instruction writes them. A halt instruction parks the processor until the next reset. Two debug outputs show the program counter and the accumulator for observation.

Top module: `acc_cpu_top`

## Requirements
- R1: While reset is asserted, the program counter, the accumulator and the three condition flags are zero, the halted output is low and no write strobe is issued. After reset is released, execution starts by fetching address 0, so a conditional jump as the first instruction is not taken.
- R2: An instruction word is 16 bits. Bits [15:12] hold the opcode and bits [11:0] hold an address X. The program counter steps by one after each instruction-word fetch.
- R3: LOAD (opcode 0) sets the accumulator to mem[X]. ADD (2) sets it to acc + mem[X]. SUB (3) sets it to acc − mem[X]. Both arithmetic results wrap modulo 2^16.
- R4: STORE (opcode 1) writes the accumulator into mem[X] with a write strobe one cycle wide and leaves the accumulator unchanged.
- R5: MOVE (opcode 11) copies mem[X] into mem[Y]. Y is bits [11:0] of the word that follows the instruction. The accumulator is not changed, and the program counter skips over that following word.
- R6: COMPARE (opcode 4) compares mem[X] with mem[Y] as unsigned numbers, where Y comes from the following word as for MOVE. It sets exactly one flag: greater when mem[X] > mem[Y], equal when they match, less otherwise. It skips the following word.
- R7: JUMP (5) always loads the program counter with X. JUMPGT (6), JUMPEQ (7) and JUMPLT (8) load it only when their own flag is set. JUMPGE (9) loads it when greater or equal is set, and JUMPLE (10) when less or equal is set. When the condition fails, execution continues at the next word.
- R8: HALT (15) raises the halted output. From then on the program counter and accumulator are frozen and no write is issued until reset.
- R9: Opcodes 12, 13 and 14 act as no-ops. They change only the program counter, which steps past them.
- R10: Counting from the first fetch cycle, instruction lengths are as follows. Jumps, no-ops and HALT take 5 cycles. STORE takes 7, LOAD/ADD/SUB take 9, MOVE takes 15 and COMPARE takes 17. The program counter shows its first increment from cycle 5 of an instruction and its second increment (MOVE, COMPARE) from cycle 14. The accumulator changes only at the boundary between instructions.
- R11: A read holds the address for one cycle while memory responds, and the captured data equals the memory output of the following cycle. Each write is a single-cycle strobe, and the total number of strobes equals the number of STORE and MOVE instructions executed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| mem_addr_o | output | ADDR_W | Memory address, driven from the address register |
| mem_wdata_o | output | DATA_W | Memory write data, driven from the data register |
| mem_we_o | output | 1 | Memory write strobe |
| mem_rdata_i | input | DATA_W | Memory read data, valid one cycle after the address |
| halted_o | output | 1 | High once HALT has executed |
| dbg_pc_o | output | ADDR_W | Current program counter |
| dbg_acc_o | output | DATA_W | Current accumulator |

## Verification
The hardest condition to reach from the ports is a conditional jump whose outcome depends on flags that no compare has written yet. The only way to reach it is to place a conditional jump at address 0, straight after reset. Reset is also applied in the middle of a looping program, so the state cleared on the next run is stale state left by a real instruction. Beyond that, the compare programs arrange operand pairs so that each of the three flag outcomes is produced. Each outcome is followed by every branch flavour both taken and not taken, and one pair has its top bit set so that a signed comparison would give the wrong answer.

// File: rtl/acc_cpu_pkg.sv
package acc_cpu_pkg;
   timeunit 1ns;
   timeprecision 1ps;

   localparam int OPC_W = 4;

   typedef enum logic [OPC_W-1:0] {
      OP_LOAD  = 4'd0,
      OP_STORE = 4'd1,
      OP_ADD   = 4'd2,
      OP_SUB   = 4'd3,
      OP_CMP   = 4'd4,
      OP_JMP   = 4'd5,
      OP_JGT   = 4'd6,
      OP_JEQ   = 4'd7,
      OP_JLT   = 4'd8,
      OP_JGE   = 4'd9,
      OP_JLE   = 4'd10,
      OP_MOVE  = 4'd11,
      OP_HALT  = 4'd15
   } opcode_e;

   typedef struct packed {
      logic gt;
      logic eq;
      logic lt;
   } cond_flags_t;

   typedef enum logic [2:0] {
      ST_FETCH,
      ST_DECODE,
      ST_RD_X,
      ST_WR_X,
      ST_RD_YA,
      ST_RD_Y,
      ST_WR_Y,
      ST_HALT
   } cpu_state_e;

   typedef enum logic [1:0] {
      MC_IDLE,
      MC_ISSUE,
      MC_WAIT,
      MC_DONE
   } mc_state_e;
endpackage

// File: rtl/acc_cpu_memctl.sv
module acc_cpu_memctl
   import acc_cpu_pkg::*;
#(
   parameter int DATA_W = 16,
   parameter int ADDR_W = 12
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_i,
   input  logic              wr_i,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic [DATA_W-1:0] wdata_i,
   output logic              ack_o,
   output logic [DATA_W-1:0] mdr_o,
   output logic [ADDR_W-1:0] mem_addr_o,
   output logic [DATA_W-1:0] mem_wdata_o,
   output logic              mem_we_o,
   input  logic [DATA_W-1:0] mem_rdata_i
);
   timeunit 1ns;
   timeprecision 1ps;

   mc_state_e         st_q;
   logic              wr_q;
   logic [ADDR_W-1:0] mar_q;
   logic [DATA_W-1:0] mdr_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q  <= MC_IDLE;
         wr_q  <= 1'b0;
         mar_q <= '0;
         mdr_q <= '0;
      end else begin
         unique case (st_q)
            MC_IDLE: begin
               if (req_i) begin
                  mar_q <= addr_i;
                  wr_q  <= wr_i;
                  if (wr_i) mdr_q <= wdata_i;
                  st_q  <= MC_ISSUE;
               end
            end
            MC_ISSUE: st_q <= wr_q ? MC_IDLE : MC_WAIT;
            MC_WAIT: begin
               mdr_q <= mem_rdata_i;
               st_q  <= MC_DONE;
            end
            default: st_q <= MC_IDLE;
         endcase
      end
   end

   assign ack_o       = ((st_q == MC_ISSUE) && wr_q) || (st_q == MC_DONE);
   assign mem_we_o    = (st_q == MC_ISSUE) && wr_q;
   assign mem_addr_o  = mar_q;
   assign mem_wdata_o = mdr_q;
   assign mdr_o       = mdr_q;

   // R11: a write strobe never lasts longer than one cycle
   p_we_single_r11: assert property (@(posedge clk) disable iff (!rst_n)
      mem_we_o |=> !mem_we_o);

   // R11: read data handed back is what memory returned one cycle earlier
   p_mdr_capture_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_o && !mem_we_o) |-> (mdr_o == $past(mem_rdata_i)));

   // R11: a read request is never acknowledged in the following cycle
   p_read_latency_r11: assert property (@(posedge clk) disable iff (!rst_n)
      ((st_q == MC_IDLE) && req_i && !wr_i) |=> !ack_o);
endmodule

// File: rtl/acc_cpu_alu.sv
module acc_cpu_alu
   import acc_cpu_pkg::*;
#(
   parameter int DATA_W = 16
) (
   input  opcode_e           op_i,
   input  logic [DATA_W-1:0] acc_i,
   input  logic [DATA_W-1:0] opnd_i,
   input  logic [DATA_W-1:0] cmp_a_i,
   input  logic [DATA_W-1:0] cmp_b_i,
   output logic [DATA_W-1:0] res_o,
   output cond_flags_t       flags_o
);
   timeunit 1ns;
   timeprecision 1ps;

   always_comb begin
      unique case (op_i)
         OP_LOAD: res_o = opnd_i;
         OP_ADD:  res_o = acc_i + opnd_i;
         OP_SUB:  res_o = acc_i - opnd_i;
         default: res_o = acc_i;
      endcase
   end

   always_comb begin
      flags_o.gt = (cmp_a_i > cmp_b_i);
      flags_o.eq = (cmp_a_i == cmp_b_i);
      flags_o.lt = (cmp_a_i < cmp_b_i);
   end
endmodule

// File: rtl/acc_cpu_branch.sv
module acc_cpu_branch
   import acc_cpu_pkg::*;
(
   input  opcode_e     op_i,
   input  cond_flags_t flags_i,
   output logic        take_o
);
   timeunit 1ns;
   timeprecision 1ps;

   always_comb begin
      unique case (op_i)
         OP_JMP:  take_o = 1'b1;
         OP_JGT:  take_o = flags_i.gt;
         OP_JEQ:  take_o = flags_i.eq;
         OP_JLT:  take_o = flags_i.lt;
         OP_JGE:  take_o = flags_i.gt | flags_i.eq;
         OP_JLE:  take_o = flags_i.lt | flags_i.eq;
         default: take_o = 1'b0;
      endcase
   end
endmodule

// File: rtl/acc_cpu_top.sv
module acc_cpu_top
   import acc_cpu_pkg::*;
#(
   parameter int DATA_W = 16,
   parameter int ADDR_W = 12
) (
   input  logic              clk,
   input  logic              rst_n,
   output logic [ADDR_W-1:0] mem_addr_o,
   output logic [DATA_W-1:0] mem_wdata_o,
   output logic              mem_we_o,
   input  logic [DATA_W-1:0] mem_rdata_i,
   output logic              halted_o,
   output logic [ADDR_W-1:0] dbg_pc_o,
   output logic [DATA_W-1:0] dbg_acc_o
);
   timeunit 1ns;
   timeprecision 1ps;

   localparam int OPF_W = DATA_W - ADDR_W;

   // R2: elaboration checks on the instruction format
   initial begin : elab_chk
      a_fmt_r2: assert (OPF_W == OPC_W)
         else $error("opcode field must be %0d bits", OPC_W);
      a_addr_r2: assert (ADDR_W >= 2)
         else $error("address field too narrow");
   end

   cpu_state_e        state_q;
   logic [ADDR_W-1:0] pc_q;
   logic [DATA_W-1:0] acc_q;
   logic [DATA_W-1:0] ir_q;
   logic [DATA_W-1:0] tmp_q;
   logic [ADDR_W-1:0] yaddr_q;
   cond_flags_t       flags_q;

   opcode_e           op;
   logic [ADDR_W-1:0] xaddr;
   logic              mc_req;
   logic              mc_wr;
   logic [ADDR_W-1:0] mc_addr;
   logic [DATA_W-1:0] mc_wdata;
   logic              mc_ack;
   logic [DATA_W-1:0] mdr;
   logic [DATA_W-1:0] alu_res;
   cond_flags_t       cmp_flags;
   logic              take;

   assign op    = opcode_e'(ir_q[DATA_W-1 -: OPF_W]);
   assign xaddr = ir_q[ADDR_W-1:0];

   // request to the transfer controller, chosen by the current phase
   always_comb begin
      mc_req   = 1'b0;
      mc_wr    = 1'b0;
      mc_addr  = pc_q;
      mc_wdata = acc_q;
      unique case (state_q)
         ST_FETCH:  mc_req = 1'b1;
         ST_RD_X: begin
            mc_req  = 1'b1;
            mc_addr = xaddr;
         end
         ST_WR_X: begin
            mc_req  = 1'b1;
            mc_wr   = 1'b1;
            mc_addr = xaddr;
         end
         ST_RD_YA:  mc_req = 1'b1;
         ST_RD_Y: begin
            mc_req  = 1'b1;
            mc_addr = yaddr_q;
         end
         ST_WR_Y: begin
            mc_req   = 1'b1;
            mc_wr    = 1'b1;
            mc_addr  = yaddr_q;
            mc_wdata = tmp_q;
         end
         default: mc_req = 1'b0;
      endcase
   end

   acc_cpu_memctl #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) memctl_i (
      .clk         (clk),
      .rst_n       (rst_n),
      .req_i       (mc_req),
      .wr_i        (mc_wr),
      .addr_i      (mc_addr),
      .wdata_i     (mc_wdata),
      .ack_o       (mc_ack),
      .mdr_o       (mdr),
      .mem_addr_o  (mem_addr_o),
      .mem_wdata_o (mem_wdata_o),
      .mem_we_o    (mem_we_o),
      .mem_rdata_i (mem_rdata_i)
   );

   acc_cpu_alu #(.DATA_W(DATA_W)) alu_i (
      .op_i    (op),
      .acc_i   (acc_q),
      .opnd_i  (mdr),
      .cmp_a_i (tmp_q),
      .cmp_b_i (mdr),
      .res_o   (alu_res),
      .flags_o (cmp_flags)
   );

   acc_cpu_branch branch_i (
      .op_i    (op),
      .flags_i (flags_q),
      .take_o  (take)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_FETCH;
         pc_q    <= '0;
         acc_q   <= '0;
         ir_q    <= '0;
         tmp_q   <= '0;
         yaddr_q <= '0;
         flags_q <= '0;
      end else begin
         unique case (state_q)
            ST_FETCH: begin
               if (mc_ack) begin
                  ir_q    <= mdr;
                  pc_q    <= pc_q + 1'b1;
                  state_q <= ST_DECODE;
               end
            end
            ST_DECODE: begin
               unique case (op)
                  OP_LOAD, OP_ADD, OP_SUB, OP_CMP, OP_MOVE: state_q <= ST_RD_X;
                  OP_STORE: state_q <= ST_WR_X;
                  OP_HALT:  state_q <= ST_HALT;
                  default: begin
                     if (take) pc_q <= xaddr;
                     state_q <= ST_FETCH;
                  end
               endcase
            end
            ST_RD_X: begin
               if (mc_ack) begin
                  if ((op == OP_CMP) || (op == OP_MOVE)) begin
                     tmp_q   <= mdr;
                     state_q <= ST_RD_YA;
                  end else begin
                     acc_q   <= alu_res;
                     state_q <= ST_FETCH;
                  end
               end
            end
            ST_RD_YA: begin
               if (mc_ack) begin
                  yaddr_q <= mdr[ADDR_W-1:0];
                  pc_q    <= pc_q + 1'b1;
                  state_q <= (op == OP_CMP) ? ST_RD_Y : ST_WR_Y;
               end
            end
            ST_RD_Y: begin
               if (mc_ack) begin
                  flags_q <= cmp_flags;
                  state_q <= ST_FETCH;
               end
            end
            ST_WR_X, ST_WR_Y: begin
               if (mc_ack) state_q <= ST_FETCH;
            end
            default: state_q <= ST_HALT;
         endcase
      end
   end

   assign halted_o  = (state_q == ST_HALT);
   assign dbg_pc_o  = pc_q;
   assign dbg_acc_o = acc_q;

   // R2: a completed instruction fetch advances the PC by exactly one
   p_pc_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
      ((state_q == ST_FETCH) && mc_ack) |=> (pc_q == ADDR_W'($past(pc_q) + 1'b1)));

   // R4: a STORE drives the accumulator value onto the write data
   p_store_data_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_we_o && (state_q == ST_WR_X)) |-> (mem_wdata_o == acc_q));

   // R6: after a compare completes exactly one flag is set
   p_flags_one_r6: assert property (@(posedge clk) disable iff (!rst_n)
      ((state_q == ST_RD_Y) && mc_ack) |=> ($countones(flags_q) == 1));

   // R6: the flags never hold more than one set bit
   p_flags_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(flags_q));

   // R8: once halted, stay halted with PC and accumulator frozen
   p_halt_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      halted_o |=> (halted_o && $stable(pc_q) && $stable(acc_q)));

   // R8: no memory write while halted
   p_halt_nowrite_r8: assert property (@(posedge clk) disable iff (!rst_n)
      halted_o |-> !mem_we_o);
endmodule

// File: tb/acc_cpu_top_tb_top.sv
module acc_cpu_top_tb_top;
   timeunit 1ns;
   timeprecision 1ps;

   localparam int DW = 16;
   localparam int AW = 12;
   localparam int MD = 256;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [AW-1:0] mem_addr;
   logic [DW-1:0] mem_wdata;
   logic [DW-1:0] mem_rdata;
   logic          mem_we;
   logic          halted;
   logic [AW-1:0] dbg_pc;
   logic [DW-1:0] dbg_acc;

   logic [DW-1:0] ram [MD];
   logic [DW-1:0] mm  [MD];
   logic          ld_en = 1'b0;
   logic [7:0]    ld_addr = '0;
   logic [DW-1:0] ld_data = '0;

   int total = 0;
   int bad   = 0;
   bit done  = 1'b0;

   always #2.5 clk = ~clk;

   acc_cpu_top #(.DATA_W(DW), .ADDR_W(AW)) dut_i (
      .clk         (clk),
      .rst_n       (rst_n),
      .mem_addr_o  (mem_addr),
      .mem_wdata_o (mem_wdata),
      .mem_we_o    (mem_we),
      .mem_rdata_i (mem_rdata),
      .halted_o    (halted),
      .dbg_pc_o    (dbg_pc),
      .dbg_acc_o   (dbg_acc)
   );

   always @(posedge clk) begin
      if (ld_en) ram[ld_addr] <= ld_data;
      else if (mem_we) ram[mem_addr[7:0]] <= mem_wdata;
      mem_rdata <= ram[mem_addr[7:0]];
   end

   function automatic logic [DW-1:0] enc(input int op, input int a);
      return {op[3:0], a[AW-1:0]};
   endfunction

   function automatic string tag_of(input logic [3:0] op);
      case (op)
         4'd0, 4'd2, 4'd3: return "R3";
         4'd1:             return "R4";
         4'd11:            return "R5";
         4'd4:             return "R6";
         4'd15:            return "R8";
         4'd12, 4'd13, 4'd14: return "R9";
         default:          return "R7";
      endcase
   endfunction

   task automatic put(input int a, input logic [DW-1:0] w);
      ld_en   = 1'b1;
      ld_addr = a[7:0];
      ld_data = w;
      mm[a[7:0]] = w;
      @(negedge clk);
      ld_en = 1'b0;
   endtask

   task automatic clear_mem();
      for (int a = 0; a < MD; a++) put(a, '0);
   endtask

   task automatic run_prog(input string nm, input bit expect_halt, input int max_cyc);
      int k, len, hold, wr_seen, m_wr;
      logic [3:0] op;
      logic [AW-1:0] pc0, x, y, m_pc, n_pc, e_pc;
      logic [DW-1:0] m_acc, n_acc, a, b;
      bit gt, eq, lt, m_halt, fin, cond;
      // R1: reset state is visible while reset is held
      #1;
      total++;
      if (dbg_pc !== '0 || dbg_acc !== '0 || halted !== 1'b0 || mem_we !== 1'b0) begin
         bad++;
         $display("FAIL R1 %s reset: pc=%h acc=%h halt=%b we=%b exp 0/0/0/0",
                  nm, dbg_pc, dbg_acc, halted, mem_we);
      end
      m_pc = '0; m_acc = '0; gt = 0; eq = 0; lt = 0; m_halt = 0;
      k = 0; len = 5; hold = 0; wr_seen = 0; m_wr = 0; fin = 0;
      op = '0; pc0 = '0; n_pc = '0; n_acc = '0;
      rst_n = 1'b1;
      for (int c = 0; c < max_cyc && !fin; c++) begin
         if (!m_halt && k == 0) begin
            pc0 = m_pc;
            op  = mm[pc0[7:0]][15:12];
            x   = mm[pc0[7:0]][AW-1:0];
            n_pc = pc0 + 1'b1;
            n_acc = m_acc;
            len = 5;
            case (op)
               4'd0: begin len = 9; n_acc = mm[x[7:0]]; end
               4'd1: begin len = 7; mm[x[7:0]] = m_acc; m_wr++; end
               4'd2: begin len = 9; n_acc = m_acc + mm[x[7:0]]; end
               4'd3: begin len = 9; n_acc = m_acc - mm[x[7:0]]; end
               4'd4: begin
                  len = 17;
                  y = mm[n_pc[7:0]][AW-1:0];
                  a = mm[x[7:0]]; b = mm[y[7:0]];
                  gt = (a > b); eq = (a == b); lt = (a < b);
                  n_pc = pc0 + 2'd2;
               end
               4'd11: begin
                  len = 15;
                  y = mm[n_pc[7:0]][AW-1:0];
                  mm[y[7:0]] = mm[x[7:0]];
                  m_wr++;
                  n_pc = pc0 + 2'd2;
               end
               4'd5, 4'd6, 4'd7, 4'd8, 4'd9, 4'd10: begin
                  cond = (op == 4'd5) || (op == 4'd6 && gt) || (op == 4'd7 && eq) ||
                         (op == 4'd8 && lt) || (op == 4'd9 && (gt || eq)) ||
                         (op == 4'd10 && (lt || eq));
                  if (cond) n_pc = x;
               end
               default: len = 5;
            endcase
         end
         if (m_halt) e_pc = m_pc;
         else if (k < 4) e_pc = pc0;
         else if (k < 13) e_pc = pc0 + 1'b1;
         else e_pc = pc0 + 2'd2;
         // R2 R10: per-cycle trace against the reference model
         total++;
         if (dbg_pc !== e_pc || dbg_acc !== m_acc || halted !== m_halt ||
             (m_halt && mem_we !== 1'b0)) begin
            bad++;
            $display("FAIL %s R2/R10 %s cyc=%0d pc=%h exp %h acc=%h exp %h halt=%b exp %b we=%b",
                     tag_of(op), nm, c, dbg_pc, e_pc, dbg_acc, m_acc, halted, m_halt, mem_we);
         end
         if (mem_we === 1'b1) wr_seen++;
         if (m_halt) begin
            hold++;
            if (hold >= 8) fin = 1;
         end else begin
            k++;
            if (k == len) begin
               m_pc = n_pc;
               m_acc = n_acc;
               k = 0;
               if (op == 4'd15) m_halt = 1;
            end
         end
         @(negedge clk);
      end
      if (expect_halt) begin
         total++;
         if (!fin) begin
            bad++;
            $display("FAIL R8 %s no halt: halted=%b exp 1", nm, halted);
         end
         // R4 R5: memory image after the run
         for (int i = 0; i < MD; i++) begin
            total++;
            if (ram[i] !== mm[i]) begin
               bad++;
               $display("FAIL R4/R5 %s mem[%0d]=%h exp %h", nm, i, ram[i], mm[i]);
            end
         end
         // R11: one strobe per STORE/MOVE
         total++;
         if (wr_seen != m_wr) begin
            bad++;
            $display("FAIL R11 %s write strobes=%0d exp %0d", nm, wr_seen, m_wr);
         end
      end
      rst_n = 1'b0;
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      if (!done) begin
         total++;
         bad++;
         $display("FAIL watchdog: run did not finish, elapsed=150000 exp less");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin : main
      @(negedge clk);
      // program 1: R1 flags clear, R3 load/add/sub wrap, R4 store
      clear_mem();
      put(0, enc(9, 10));
      put(1, enc(0, 'h80));
      put(2, enc(2, 'h81));
      put(3, enc(3, 'h82));
      put(4, enc(1, 'h90));
      put(5, enc(0, 'h90));
      put(6, enc(8, 10));
      put(7, enc(15, 0));
      put(10, enc(15, 0));
      put('h80, 16'hFFF0);
      put('h81, 16'h0020);
      put('h82, 16'h0030);
      run_prog("arith", 1'b1, 400);

      // program 2: R6 three flag outcomes, R7 every jump taken/not taken
      clear_mem();
      put(0, enc(4, 'h80));  put(1, 'h81);
      put(2, enc(8, 'h70));  put(3, enc(7, 'h70));
      put(4, enc(10, 'h70)); put(5, enc(6, 7));
      put(6, enc(15, 0));    put(7, enc(9, 9));
      put(8, enc(15, 0));
      put(9, enc(4, 'h81));  put(10, 'h80);
      put(11, enc(9, 'h70)); put(12, enc(10, 14));
      put(13, enc(15, 0));   put(14, enc(8, 16));
      put(15, enc(15, 0));
      put(16, enc(4, 'h82)); put(17, 'h83);
      put(18, enc(6, 'h70)); put(19, enc(8, 'h70));
      put(20, enc(7, 22));   put(21, enc(15, 0));
      put(22, enc(9, 24));   put(23, enc(15, 0));
      put(24, enc(10, 26));  put(25, enc(15, 0));
      put(26, enc(0, 'h84)); put(27, enc(1, 'h91));
      put(28, enc(5, 30));   put(29, enc(15, 0));
      put(30, enc(15, 0));
      put('h70, enc(15, 0));
      put('h80, 16'd5); put('h81, 16'd3);
      put('h82, 16'h0777); put('h83, 16'h0777);
      put('h84, 16'hA5A5);
      run_prog("branch", 1'b1, 1200);

      // program 3: R5 move, R9 undefined opcodes, R6 unsigned compare
      clear_mem();
      put(0, enc(0, 'h80));
      put(1, enc(11, 'h81)); put(2, 'h92);
      put(3, enc(12, 'h55)); put(4, enc(13, 'h56));
      put(5, enc(14, 'h57));
      put(6, enc(4, 'h85));  put(7, 'h86);
      put(8, enc(6, 10));    put(9, enc(15, 0));
      put(10, enc(1, 'h93)); put(11, enc(0, 'h92));
      put(12, enc(15, 0));
      put('h80, 16'h1234); put('h81, 16'hBEEF);
      put('h85, 16'h8000); put('h86, 16'h0001);
      run_prog("move", 1'b1, 600);

      // program 4: endless loop, reset lands mid-instruction (R1 on next run)
      clear_mem();
      put(0, enc(2, 'h80));
      put(1, enc(5, 0));
      put('h80, 16'h0003);
      run_prog("loop", 1'b0, 151);

      // program 5: rerun after mid-run reset, R8 halt immediately
      clear_mem();
      put(0, enc(7, 3));
      put(1, enc(15, 0));
      put(3, enc(0, 'h80));
      put('h80, 16'h0042);
      run_prog("rehalt", 1'b1, 200);

      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule